// File: doc/BRIEF.md
# Two-Wire Register Target with Row-Wrapped Writes

This block is a synchronous two-wire (I2C) target. It samples the SCL and SDA lines with the system clock, detects START, repeated START and STOP, and answers one 7-bit bus address. The block holds a memory address counter and uses it to read from and write to an attached register file. After the address byte, a write carries one memory address byte and then data bytes. Data writes stay inside a two-byte row that starts at an even address. A read returns bytes from the counter and moves the counter forward for as long as the master acknowledges.

The bus address is either a fixed value or the upper seven bits of register 0, and an input pin chooses between them. While the attached nonvolatile store reports busy, the block refuses its own address. On a STOP that ends a transaction in which at least one data byte was written, the block gives a one-cycle pulse to the commit logic. It has no clock stretching, no 10-bit addressing and no general call.

Top module: `i2cRegSlave`

## Requirements
- R1: With `addrSel` low, the block answers the 7-bit address 51h (write byte A2h, read byte A3h). With `addrSel` high, it answers `storedAddr[7:1]` and ignores `storedAddr[0]`. In either case it does not answer any other address.
- R2: Bytes on the bus are sent most significant bit first. The ninth clock of each byte is the acknowledge: SDA low means ACK and SDA high means NACK. The block ACKs its own address byte and every byte written to it.
- R3: After an address byte that does not match, the block drives no SDA low and writes no register until the next START.
- R4: In a write, the byte after the address byte sets the counter from its low 5 bits. Each following data byte is written to the counter's location.
- R5: A data write toggles only bit 0 of the counter. A third data byte starting at row address 02h is written to 02h again, and 03h keeps the second byte.
- R6: A read returns the byte at the counter and adds 1 to the counter after each byte, wrapping from 1Fh to 00h. The read goes on while the master ACKs and ends on a NACK. A read that follows with no new memory address continues from the counter.
- R7: A write that carries only the memory address byte and then a repeated START sets the location that the next read returns.
- R8: While `storeBusy` is high when the address byte completes, the block NACKs its address.
- R9: The block changes its SDA drive only while SCL is low, after a falling edge.
- R10: Locations 08h to 0Fh are not implemented. Reads there return 00h, writes there give no `regWrEn`, and the counter still moves on.
- R11: `txnEnd` pulses for one cycle on a STOP only when a data byte was written since the previous STOP. A transaction with only an address does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOutEn | output | 1 | 1 pulls SDA low |
| addrSel | input | 1 | 0 selects the fixed bus address, 1 selects the stored address |
| storedAddr | input | 8 | Register 0 contents; bits 7:1 form the stored bus address |
| storeBusy | input | 1 | The nonvolatile store is writing |
| regAddr | output | 5 | Register file location, used for both read and write |
| regWrEn | output | 1 | Write strobe for the register file |
| regWrData | output | 8 | Write data for the register file |
| regRdData | input | 8 | Register file data at `regAddr`, read without delay |
| txnEnd | output | 1 | One-cycle pulse at the end of a write transaction |

## Verification
The row wrap and the acknowledge decision happen on the same detected SCL falling edge. On that edge the block writes the data byte, toggles the counter's bit 0 and starts driving the ACK. A three-byte write into row 02h provokes this case. It is judged by the final contents of 02h and 03h and by the ACK seen for every byte. A second case is a read that crosses 1Fh. There, loading the next byte and wrapping the counter fall in the same cycle, and the bench compares the bytes returned after the wrap with the values it preloaded at 1Eh, 1Fh and 00h.

// File: rtl/i2cSlvPkg.sv
package i2cSlvPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ACKA, ST_RXA, ST_RXD, ST_ACKW, ST_TX, ST_MACK
  } ctrlState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic clrBit;   // restart the bit counter
    logic ldCnt;    // load the address counter from the received byte
    logic rowInc;   // step the counter inside its two-byte row
    logic rdLoad;   // fetch the byte at the counter, then counter + 1
    logic txShift;  // move to the next transmit bit
    logic wr;       // write the received byte at the counter
    logic drvAck;   // hold SDA low for an acknowledge
    logic drvTx;    // drive the transmit shift register
  } dpStrobe_t;

endpackage

// File: rtl/i2cSlvDp.sv
module i2cSlvDp
  import i2cSlvPkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int HOLE_LO = 8,
  parameter int HOLE_HI = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [7:0]        regRdData,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic [3:0]        bitCnt,
  output logic [7:0]        rxByte,
  output logic              sdaOutEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn
);

  localparam logic [ADDR_W-1:0] HoleLo = ADDR_W'(HOLE_LO);
  localparam logic [ADDR_W-1:0] HoleHi = ADDR_W'(HOLE_HI);

  logic [1:0]        sclSync, sdaSync;
  logic              sclS, sdaS, sclP, sdaP, sclRise;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0]        txReg;
  logic              inHole;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;

  assign inHole = (addrCnt >= HoleLo) && (addrCnt <= HoleHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      addrCnt <= '0;
      txReg   <= '0;
    end else begin
      if (strb.clrBit)                     bitCnt <= '0;
      else if (sclRise && bitCnt < 4'd9)   bitCnt <= bitCnt + 4'd1;

      if (sclRise) rxByte <= {rxByte[6:0], sdaS};

      if (strb.ldCnt)       addrCnt    <= rxByte[ADDR_W-1:0];
      else if (strb.rowInc) addrCnt[0] <= ~addrCnt[0];
      else if (strb.rdLoad) addrCnt    <= addrCnt + 1'b1;

      if (strb.rdLoad)       txReg <= inHole ? 8'h00 : regRdData;
      else if (strb.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign sdaOutEn  = strb.drvAck | (strb.drvTx & ~txReg[7]);
  assign regAddr   = addrCnt;
  assign regWrData = rxByte;
  assign regWrEn   = strb.wr & ~inHole;

  // R5: a data write stays inside its row and flips bit 0
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> (addrCnt[ADDR_W-1:1] == $past(addrCnt[ADDR_W-1:1])) &&
                (addrCnt[0] != $past(addrCnt[0])));

  // R6: each byte fetched for reading advances the counter by one, wrapping
  a_r6_read_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && !strb.ldCnt && !strb.rowInc) |=> addrCnt == $past(addrCnt) + 1'b1);

  // R9: drive changes only follow a sampled low SCL
  a_r9_sda_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOutEn) |-> !$past(sclS));

endmodule

// File: rtl/i2cSlvCtrl.sv
module i2cSlvCtrl
  import i2cSlvPkg::*;
#(
  parameter logic [6:0] FIXED_ADDR = 7'h51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       addrSel,
  input  logic [7:0] storedAddr,
  input  logic       storeBusy,
  output dpStrobe_t  strb,
  output logic       txnEnd
);

  ctrlState_e state, nxt;
  logic       rdMode, wrote, byteEnd, ninthEnd, addrHit;
  logic [6:0] ownAddr;

  assign byteEnd  = sclFall && (bitCnt == 4'd8);
  assign ninthEnd = sclFall && (bitCnt == 4'd9);
  assign ownAddr  = addrSel ? storedAddr[7:1] : FIXED_ADDR;
  // bit 0 of the stored register sits in the R/W position; it appears on both sides
  assign addrHit  = {rxByte[7:1], storedAddr[0]} == {ownAddr, storedAddr[0]};

  always_comb begin
    strb        = '0;
    nxt         = state;
    strb.drvAck = (state == ST_ACKA) || (state == ST_ACKW);
    strb.drvTx  = (state == ST_TX);
    case (state)
      ST_DEV:  if (byteEnd) nxt = (addrHit && !storeBusy) ? ST_ACKA : ST_IDLE;
      ST_ACKA: if (ninthEnd) begin
                 strb.clrBit = 1'b1;
                 if (rdMode) begin
                   strb.rdLoad = 1'b1;
                   nxt = ST_TX;
                 end else nxt = ST_RXA;
               end
      ST_RXA:  if (byteEnd) begin
                 strb.ldCnt = 1'b1;
                 nxt = ST_ACKW;
               end
      ST_ACKW: if (ninthEnd) begin
                 strb.clrBit = 1'b1;
                 nxt = ST_RXD;
               end
      ST_RXD:  if (byteEnd) begin
                 strb.wr     = 1'b1;
                 strb.rowInc = 1'b1;
                 nxt = ST_ACKW;
               end
      ST_TX:   if (sclFall) begin
                 if (bitCnt == 4'd8) nxt = ST_MACK;
                 else strb.txShift = 1'b1;
               end
      ST_MACK: if (ninthEnd) begin
                 strb.clrBit = 1'b1;
                 if (!rxByte[0]) begin
                   strb.rdLoad = 1'b1;
                   nxt = ST_TX;
                 end else nxt = ST_IDLE;
               end
      default: ;
    endcase
    if (startSeen) begin
      strb        = '0;
      strb.clrBit = 1'b1;
      nxt         = ST_DEV;
    end else if (stopSeen) begin
      strb = '0;
      nxt  = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdMode <= 1'b0;
      wrote  <= 1'b0;
      txnEnd <= 1'b0;
    end else begin
      state  <= nxt;
      if (state == ST_DEV && byteEnd) rdMode <= rxByte[0];
      txnEnd <= stopSeen && wrote;
      if (stopSeen)     wrote <= 1'b0;
      else if (strb.wr) wrote <= 1'b1;
    end
  end

  // R8: a busy store turns the address byte away
  a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && byteEnd && storeBusy && !startSeen) |=> state == ST_IDLE);

  // R11: the commit pulse only ever follows a STOP
  a_r11_end_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    txnEnd |-> $past(stopSeen));

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cSlvPkg::*;
#(
  parameter int         ADDR_W     = 5,
  parameter int         HOLE_LO    = 8,
  parameter int         HOLE_HI    = 15,
  parameter logic [6:0] FIXED_ADDR = 7'h51
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOutEn,
  input  logic              addrSel,
  input  logic [7:0]        storedAddr,
  input  logic              storeBusy,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData,
  output logic              txnEnd
);

  dpStrobe_t  strb;
  logic       sclFall, startSeen, stopSeen;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  i2cSlvCtrl #(.FIXED_ADDR(FIXED_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .bitCnt(bitCnt), .rxByte(rxByte), .addrSel(addrSel),
    .storedAddr(storedAddr), .storeBusy(storeBusy), .strb(strb), .txnEnd(txnEnd)
  );

  i2cSlvDp #(.ADDR_W(ADDR_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .regRdData(regRdData), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .bitCnt(bitCnt), .rxByte(rxByte), .sdaOutEn(sdaOutEn),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn)
  );

endmodule

// File: tb/i2cRegSlave_test.sv
module i2cRegSlave_test;

  localparam int Q = 8;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       addrSel = 1'b0, storeBusy = 1'b0;
  logic       sdaOutEn, regWrEn, txnEnd, sdaLine;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [32];
  int         tests = 0, fails = 0, endPulses = 0, drvCycles = 0, highChanges = 0;
  logic       prevDrv = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOutEn;
  assign regRdData = mem[regAddr];

  i2cRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOutEn(sdaOutEn),
    .addrSel(addrSel), .storedAddr(mem[0]), .storeBusy(storeBusy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .txnEnd(txnEnd)
  );

  function automatic logic [7:0] pre(int i);
    return 8'(i * 13 + 5);
  endfunction

  initial for (int i = 0; i < 32; i++) mem[i] = pre(i);

  always @(posedge clk) if (regWrEn) mem[regAddr] <= regWrData;

  always @(negedge clk) begin
    if (txnEnd) endPulses++;
    if (sdaOutEn) drvCycles++;
    if (sdaOutEn != prevDrv && sclM) highChanges++;
    prevDrv = sdaOutEn;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(H); sdaM = 1'b0; tick(H); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(H); sdaM = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(H); sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(H / 2);
    ack = ~sdaLine;
    tick(H / 2); sclM = 1'b0; tick(Q);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(H / 2); b[i] = sdaLine; tick(H / 2); sclM = 1'b0;
    end
    tick(Q); sdaM = ~giveAck; tick(Q); sclM = 1'b1; tick(H); sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic testReset();
    check(!sdaOutEn && !regWrEn && !txnEnd, "reset outputs idle", sdaOutEn, 0);
  endtask

  task automatic testSingleWrite();
    logic a0, a1, a2;
    int p = endPulses;
    busStart(); sendByte(8'hA2, a0); sendByte(8'h02, a1); sendByte(8'h7F, a2); busStop();
    check(a0 && a1 && a2, "R2 acks on write", {a0, a1, a2}, 3'b111);
    check(mem[2] == 8'h7F, "R4 single write", mem[2], 8'h7F);
    check(endPulses == p + 1, "R11 pulse after write", endPulses - p, 1);
  endtask

  task automatic testPairWrite();
    logic a;
    busStart(); sendByte(8'hA2, a); sendByte(8'h04, a); sendByte(8'hAB, a); sendByte(8'hCD, a);
    busStop();
    check(mem[4] == 8'hAB && mem[5] == 8'hCD, "R4 consecutive write", {mem[4], mem[5]}, 16'hABCD);
  endtask

  task automatic testRowWrap();
    logic a;
    busStart(); sendByte(8'hA2, a); sendByte(8'h02, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a);
    busStop();
    check(a, "R2 ack on wrapped byte", a, 1);
    check(mem[2] == 8'h33 && mem[3] == 8'h22, "R5 row wrap", {mem[2], mem[3]}, 16'h3322);
  endtask

  task automatic testRandomRead();
    logic a;
    logic [7:0] d;
    int p = endPulses;
    busStart(); sendByte(8'hA2, a); sendByte(8'h03, a);
    busStart(); sendByte(8'hA3, a); readByte(1'b0, d); busStop();
    check(d == 8'h22, "R7 set address then read", d, 8'h22);
    check(endPulses == p, "R11 no pulse on address-only", endPulses - p, 0);
  endtask

  task automatic testSeqRead();
    logic a;
    logic [7:0] d0, d1, d2, d3;
    busStart(); sendByte(8'hA2, a); sendByte(8'h1E, a);
    busStart(); sendByte(8'hA3, a);
    readByte(1'b1, d0); readByte(1'b1, d1); readByte(1'b0, d2); busStop();
    check(d0 == pre(30) && d1 == pre(31), "R6 sequential read", {d0, d1}, {pre(30), pre(31)});
    check(d2 == pre(0), "R6 wrap 1F to 00", d2, pre(0));
    busStart(); sendByte(8'hA3, a); readByte(1'b0, d3); busStop();
    check(d3 == pre(1), "R6 continue from counter", d3, pre(1));
  endtask

  task automatic testHole();
    logic a;
    logic [7:0] d0, d1;
    busStart(); sendByte(8'hA2, a); sendByte(8'h08, a); sendByte(8'h55, a); busStop();
    check(mem[8] == pre(8), "R10 hole write dropped", mem[8], pre(8));
    busStart(); sendByte(8'hA2, a); sendByte(8'h0F, a);
    busStart(); sendByte(8'hA3, a); readByte(1'b1, d0); readByte(1'b0, d1); busStop();
    check(d0 == 8'h00, "R10 hole reads zero", d0, 0);
    check(d1 == pre(16), "R10 counter moves past hole", d1, pre(16));
  endtask

  task automatic testMismatch();
    logic a0, a1, a2;
    int dc;
    busStart();
    dc = drvCycles;
    sendByte(8'hA4, a0); sendByte(8'h02, a1); sendByte(8'h99, a2); busStop();
    check(!a0, "R3 foreign address NACK", a0, 0);
    check(drvCycles == dc && mem[2] == 8'h33, "R3 bus ignored", drvCycles - dc, 0);
  endtask

  task automatic testAddrSel();
    logic a0, a1;
    busStart(); sendByte(8'hA2, a0); sendByte(8'h00, a0); sendByte(8'h5B, a0); busStop();
    addrSel = 1'b1;
    busStart(); sendByte(8'h5A, a0); sendByte(8'h03, a1); sendByte(8'h44, a1); busStop();
    check(a0 && mem[3] == 8'h44, "R1 stored address, bit0 ignored", mem[3], 8'h44);
    busStart(); sendByte(8'hA2, a1); busStop();
    check(!a1, "R1 fixed address off when pin high", a1, 0);
    addrSel = 1'b0;
  endtask

  task automatic testBusy();
    logic a0, a1;
    int p;
    storeBusy = 1'b1;
    busStart(); sendByte(8'hA2, a0); busStop();
    storeBusy = 1'b0;
    p = endPulses;
    busStart(); sendByte(8'hA2, a1); busStop();
    check(!a0, "R8 NACK while busy", a0, 0);
    check(a1 && endPulses == p, "R8 ACK when idle, R11 no pulse", {a1, 8'(endPulses - p)}, 9'h100);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    tick(4);
    testReset();
    testSingleWrite();
    testPairWrite();
    testRowWrap();
    testRandomRead();
    testSeqRead();
    testHole();
    testMismatch();
    testAddrSel();
    testBusy();
    check(highChanges == 0, "R9 drive changes with SCL low", highChanges, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule